// File: doc/BRIEF.md
# Scaled Pixel Multiplier

This block forms, for every pixel position of two equally sized images, the product of the two intensities and scales that product by a fraction between zero and one. Both images arrive pixel-aligned on two valid/ready input streams. The result leaves on a third stream, with the same pixel type and element count as the inputs. One elaboration parameter selects what happens when a result does not fit the output width: the value either wraps or is clamped.

Element width, signedness, channel count (one or three) and pixels per beat (one or eight) are all parameters. One instance therefore covers unsigned 8-bit and signed 16-bit images, grey or colour, at one or eight pixels per clock. In eight-pixel use the image width must be a multiple of eight. The scale is a runtime input in unsigned fixed point with `FRAC_W` fractional bits. Every element of every beat is computed independently with the scale that was present when its beat was accepted.

Top module: `pixel_mul_scale`

## Requirements
- R1: Each output element equals round(a × b × scale / 2^FRAC_W). Here a and b are the elements at the same lane of the two inputs, read as signed when `SIGNED_PIX`=1 and unsigned otherwise. The scale is read as an unsigned integer, with 1.0 encoded as 2^FRAC_W (0x10000 for FRAC_W=16).
- R2: Rounding goes to the nearest integer, and exact halves go away from zero (1.5→2, −1.5→−2, −0.5→−1, −0.25→0).
- R3: With `SATURATE`=0, the output element is the low `PIX_W` bits of the rounded result in two's complement (200×200×1.0 on 8-bit unsigned gives 0x40).
- R4: With `SATURATE`=1, a rounded result above the largest representable value gives that value, and one below the smallest gives the smallest. For signed 16-bit these are 32767 and −32768; for unsigned they are 2^PIX_W−1 and 0.
- R5: A scale input above 2^FRAC_W is used as exactly 2^FRAC_W.
- R6: Lane k occupies data bits [k·PIX_W +: PIX_W]. Pixel p, channel c is lane p·CHANNELS+c. Lanes do not influence each other, and all lanes of a beat use the same scale.
- R7: A beat is taken only when both inputs are valid and the pipeline can advance (output empty or output ready). `a_ready` is never high while `b_valid` is low, and `b_ready` is never high while `a_valid` is low. Both inputs are consumed in the same cycle.
- R8: While `o_valid` is high and `o_ready` is low, `o_valid`, `o_data` and `o_last` hold, and no new input beat is taken once the internal stage is full.
- R9: Beats leave in the order they were taken. With no backpressure, a beat taken at clock edge n appears on `o_valid` after edge n+1. At most two beats are ever in flight.
- R10: `o_last` on each output beat equals `a_last` of the input beat it came from.
- R11: After reset, `o_valid` is low, and `a_ready` is low while `b_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scale | input | FRAC_W+1 | Unsigned fixed-point scale, 1.0 = 2^FRAC_W |
| a_valid | input | 1 | First image beat valid |
| a_ready | output | 1 | First image beat accepted |
| a_data | input | CHANNELS·PIX_PER_CLK·PIX_W | First image elements |
| a_last | input | 1 | Last beat of frame, carried through |
| b_valid | input | 1 | Second image beat valid |
| b_ready | output | 1 | Second image beat accepted |
| b_data | input | CHANNELS·PIX_PER_CLK·PIX_W | Second image elements |
| o_valid | output | 1 | Result beat valid |
| o_ready | input | 1 | Downstream accepts result |
| o_data | output | CHANNELS·PIX_PER_CLK·PIX_W | Result elements |
| o_last | output | 1 | Last beat of frame, aligned with `o_data` |

## Verification
The delicate overlap is a held result draining in the same cycle that a new input pair is accepted. This happens on release of backpressure and throughout a burst where `o_ready` toggles. The bench provokes it in two ways: it fills the pipeline under a stalled output and then raises `o_ready` with a second pair already waiting, and it runs a six-beat burst against a ready pattern of two-on, one-off. A scoreboard computes every expected beat, including its last flag, from the inputs at the moment of handshake and compares outputs in order. The bench also counts the cycles in which acceptance and emission coincide, and that count must be non-zero.

// File: rtl/pixel_mul_scale.sv
module pixel_mul_scale #(
  parameter int PIX_W       = 16,
  parameter bit SIGNED_PIX  = 1'b1,
  parameter int CHANNELS    = 1,
  parameter int PIX_PER_CLK = 1,
  parameter bit SATURATE    = 1'b1,
  parameter int FRAC_W      = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [FRAC_W:0]                       scale,
  input  logic                                  a_valid,
  output logic                                  a_ready,
  input  logic [CHANNELS*PIX_PER_CLK*PIX_W-1:0] a_data,
  input  logic                                  a_last,
  input  logic                                  b_valid,
  output logic                                  b_ready,
  input  logic [CHANNELS*PIX_PER_CLK*PIX_W-1:0] b_data,
  output logic                                  o_valid,
  input  logic                                  o_ready,
  output logic [CHANNELS*PIX_PER_CLK*PIX_W-1:0] o_data,
  output logic                                  o_last
);

  localparam int LANES = CHANNELS * PIX_PER_CLK;
  localparam int DW    = LANES * PIX_W;
  localparam int EW    = PIX_W + 1;
  localparam int PW    = 2 * EW;
  localparam int SW    = FRAC_W + 2;
  localparam int FW    = PW + SW;
  localparam int RW    = FW - FRAC_W;
  localparam logic [FRAC_W:0] UNITY = {1'b1, {FRAC_W{1'b0}}};
  localparam logic [FW-1:0]   HALF  = FW'(1) << (FRAC_W - 1);

  logic              adv, take;
  logic              s1_valid, s1_last;
  logic [FRAC_W:0]   s1_scale, scale_c;
  logic [LANES*PW-1:0] prod_d, s1_prod;
  logic [DW-1:0]     res_d;

  assign adv     = !o_valid || o_ready;
  assign take    = a_valid && b_valid && adv;
  assign a_ready = adv && b_valid;
  assign b_ready = adv && a_valid;
  assign scale_c = (scale > UNITY) ? UNITY : scale;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [EW-1:0] ea, eb;
    logic signed [PW-1:0] p;
    logic signed [FW-1:0] full, biased;

    assign ea = {SIGNED_PIX & a_data[k*PIX_W+PIX_W-1], a_data[k*PIX_W +: PIX_W]};
    assign eb = {SIGNED_PIX & b_data[k*PIX_W+PIX_W-1], b_data[k*PIX_W +: PIX_W]};
    assign p  = PW'(ea) * PW'(eb);
    assign prod_d[k*PW +: PW] = p;

    assign full   = FW'($signed(s1_prod[k*PW +: PW])) * FW'($signed({1'b0, s1_scale}));
    assign biased = full + $signed(HALF) - $signed(FW'(full[FW-1]));

    if (SATURATE) begin : g_sat
      localparam longint MAXL = SIGNED_PIX ? (64'sd1 <<< (PIX_W-1)) - 64'sd1
                                           : (64'sd1 <<< PIX_W) - 64'sd1;
      localparam longint MINL = SIGNED_PIX ? -(64'sd1 <<< (PIX_W-1)) : 64'sd0;
      localparam logic signed [RW-1:0] MAXV = RW'(MAXL);
      localparam logic signed [RW-1:0] MINV = RW'(MINL);
      logic signed [RW-1:0] rnd;
      assign rnd = RW'(biased >>> FRAC_W);
      assign res_d[k*PIX_W +: PIX_W] = (rnd > MAXV) ? MAXV[PIX_W-1:0] :
                                       (rnd < MINV) ? MINV[PIX_W-1:0] : rnd[PIX_W-1:0];
    end else begin : g_wrap
      assign res_d[k*PIX_W +: PIX_W] = PIX_W'(biased >>> FRAC_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
      s1_scale <= '0;
      s1_prod  <= '0;
      o_valid  <= 1'b0;
      o_last   <= 1'b0;
      o_data   <= '0;
    end else if (adv) begin
      s1_valid <= take;
      o_valid  <= s1_valid;
      o_last   <= s1_last;
      o_data   <= res_d;
      if (take) begin
        s1_last  <= a_last;
        s1_scale <= scale_c;
        s1_prod  <= prod_d;
      end
    end
  end

endmodule

// File: rtl/pixel_mul_scale_chk.sv
module pixel_mul_scale_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_valid,
  input logic          a_ready,
  input logic          b_valid,
  input logic          b_ready,
  input logic          o_valid,
  input logic          o_ready,
  input logic [DW-1:0] o_data,
  input logic          o_last
);

  logic [2:0] inflight;
  logic       took, gave;

  assign took = a_valid && a_ready;
  assign gave = o_valid && o_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + {2'b0, took} - {2'b0, gave};
  end

  assert_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    took |-> (b_valid && b_ready));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    took |-> (!o_valid || o_ready));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_last)));

  assert_inflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd2);

  assert_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> (inflight != 3'd0));

endmodule

bind pixel_mul_scale pixel_mul_scale_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_ready(a_ready),
  .b_valid(b_valid), .b_ready(b_ready),
  .o_valid(o_valid), .o_ready(o_ready),
  .o_data(o_data), .o_last(o_last)
);

// File: tb/tb_pixel_mul_scale.sv
`timescale 1ns/1ps
module tb_pixel_mul_scale;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int both_cnt = 0;
  string cur_tag = "R1";

  logic [16:0]  x_sc;
  logic         x_av, x_bv, x_al, x_ar, x_br, x_ov, x_or, x_ol;
  logic [127:0] x_ad, x_bd, x_od;
  logic [16:0]  y_sc;
  logic         y_av, y_bv, y_al, y_ar, y_br, y_ov, y_or, y_ol;
  logic [23:0]  y_ad, y_bd, y_od;

  pixel_mul_scale #(.PIX_W(16), .SIGNED_PIX(1'b1), .CHANNELS(1), .PIX_PER_CLK(8),
                    .SATURATE(1'b1), .FRAC_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .scale(x_sc),
    .a_valid(x_av), .a_ready(x_ar), .a_data(x_ad), .a_last(x_al),
    .b_valid(x_bv), .b_ready(x_br), .b_data(x_bd),
    .o_valid(x_ov), .o_ready(x_or), .o_data(x_od), .o_last(x_ol));

  pixel_mul_scale #(.PIX_W(8), .SIGNED_PIX(1'b0), .CHANNELS(3), .PIX_PER_CLK(1),
                    .SATURATE(1'b0), .FRAC_W(16)) dut_wrap (
    .clk(clk), .rst_n(rst_n), .scale(y_sc),
    .a_valid(y_av), .a_ready(y_ar), .a_data(y_ad), .a_last(y_al),
    .b_valid(y_bv), .b_ready(y_br), .b_data(y_bd),
    .o_valid(y_ov), .o_ready(y_or), .o_data(y_od), .o_last(y_ol));

  function automatic longint model(input longint a, input longint b, input longint s,
                                   input int w, input bit sgn, input bit sat);
    longint f, q, mx, mn, ss;
    ss = (s > 65536) ? 65536 : s;
    f  = a * b * ss;
    if (f >= 0) q = (f + 32768) / 65536;
    else        q = -((32768 - f) / 65536);
    mx = sgn ? (64'sd1 <<< (w-1)) - 1 : (64'sd1 <<< w) - 1;
    mn = sgn ? -(64'sd1 <<< (w-1)) : 64'sd0;
    if (sat) begin
      if (q > mx) q = mx;
      else if (q < mn) q = mn;
    end
    return q;
  endfunction

  function automatic logic [127:0] x_expect(input logic [127:0] a, b, input logic [16:0] s);
    logic [127:0] r;
    for (int k = 0; k < 8; k++)
      r[k*16 +: 16] = 16'(model($signed(a[k*16 +: 16]), $signed(b[k*16 +: 16]), s, 16, 1'b1, 1'b1));
    return r;
  endfunction

  function automatic logic [23:0] y_expect(input logic [23:0] a, b, input logic [16:0] s);
    logic [23:0] r;
    for (int k = 0; k < 3; k++)
      r[k*8 +: 8] = 8'(model(a[k*8 +: 8], b[k*8 +: 8], s, 8, 1'b0, 1'b0));
    return r;
  endfunction

  function automatic logic [127:0] v8(input int e0, e1, e2, e3, e4, e5, e6, e7);
    return {16'(e7), 16'(e6), 16'(e5), 16'(e4), 16'(e3), 16'(e2), 16'(e1), 16'(e0)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [127:0] xq_d[$];
  bit           xq_l[$];
  string        xq_t[$];
  logic [23:0]  yq_d[$];
  bit           yq_l[$];
  string        yq_t[$];

  always @(negedge clk) begin
    if (rst_n) begin
      if (x_ov && x_or) begin
        if (xq_d.size() == 0) chk(1'b0, "R9 output without input", x_od, 0);
        else begin
          logic [127:0] e;
          bit l;
          string t;
          e = xq_d.pop_front(); l = xq_l.pop_front(); t = xq_t.pop_front();
          chk(x_od == e, t, x_od, e);
          chk(x_ol == l, {t, " last flag R10"}, x_ol, l);
        end
      end
      if (x_av && x_ar && x_ov && x_or) both_cnt++;
      if (x_av && x_ar) begin
        xq_d.push_back(x_expect(x_ad, x_bd, x_sc));
        xq_l.push_back(x_al);
        xq_t.push_back(cur_tag);
      end
      if (y_ov && y_or) begin
        if (yq_d.size() == 0) chk(1'b0, "R9 output without input (wrap)", y_od, 0);
        else begin
          logic [23:0] e;
          bit l;
          string t;
          e = yq_d.pop_front(); l = yq_l.pop_front(); t = yq_t.pop_front();
          chk(y_od == e, t, y_od, e);
          chk(y_ol == l, {t, " last flag R10"}, y_ol, l);
        end
      end
      if (y_av && y_ar) begin
        yq_d.push_back(y_expect(y_ad, y_bd, y_sc));
        yq_l.push_back(y_al);
        yq_t.push_back(cur_tag);
      end
    end
  end

  task automatic x_send(input logic [127:0] a, b, input logic l);
    x_ad = a; x_bd = b; x_al = l; x_av = 1'b1; x_bv = 1'b1;
    do @(negedge clk); while (!x_ar);
    @(posedge clk); #1;
  endtask

  task automatic x_idle;
    x_av = 1'b0; x_bv = 1'b0; x_al = 1'b0;
  endtask

  task automatic x_drain(input string tag);
    x_or = 1'b1;
    repeat (8) @(negedge clk);
    chk(xq_d.size() == 0, tag, xq_d.size(), 0);
    @(posedge clk); #1;
  endtask

  task automatic y_send(input logic [23:0] a, b, input logic l);
    y_ad = a; y_bd = b; y_al = l; y_av = 1'b1; y_bv = 1'b1;
    do @(negedge clk); while (!y_ar);
    @(posedge clk); #1;
  endtask

  task automatic y_idle;
    y_av = 1'b0; y_bv = 1'b0; y_al = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(x_ov == 1'b0, "R11 o_valid low after reset", x_ov, 0);
    chk(y_ov == 1'b0, "R11 o_valid low after reset (wrap)", y_ov, 0);
    chk(x_ar == 1'b0, "R11 a_ready low with b idle", x_ar, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_basic;
    cur_tag = "R1 R6 unity scale lanes";
    x_sc = 17'h10000;
    x_send(v8(100, -200, 7, 0, -1, 32767, 12, -5), v8(200, 3, -9, 1234, -1, 1, -12, -5), 1'b0);
    cur_tag = "R1 R6 scale 0.75";
    x_sc = 17'h0C000;
    x_send(v8(10, 20, -30, 40, 55, -66, 77, 1), v8(3, -7, 11, 13, 9, 5, -2, 1), 1'b0);
    x_idle;
    x_drain("R9 basic beats all emerged");
  endtask

  task automatic t_round;
    cur_tag = "R2 half scale ties";
    x_sc = 17'h08000;
    x_send(v8(3, -3, 5, -1, 1, 2, 0, -7), v8(1, 1, 1, 1, 1, 1, 1, 1), 1'b0);
    cur_tag = "R2 quarter scale";
    x_sc = 17'h04000;
    x_send(v8(3, -3, 1, -1, 2, -2, 6, -6), v8(1, 1, 1, 1, 1, 1, 1, 1), 1'b0);
    x_idle;
    x_drain("R9 rounding beats all emerged");
  endtask

  task automatic t_sat;
    cur_tag = "R4 clamp at both ends";
    x_sc = 17'h10000;
    x_send(v8(300, -300, -32768, 32767, 200, -200, 181, -182),
           v8(300, 300, -32768, 32767, -200, 200, 181, 181), 1'b0);
    cur_tag = "R1 zero scale";
    x_sc = 17'h00000;
    x_send(v8(300, -300, 5, 6, 7, 8, 9, 10), v8(300, 300, 5, 6, 7, 8, 9, 10), 1'b0);
    x_idle;
    x_drain("R9 saturation beats all emerged");
  endtask

  task automatic t_clamp;
    cur_tag = "R5 oversize scale used as one";
    x_sc = 17'h1FFFF;
    x_send(v8(10, -10, 99, 3, 0, 1, -1, 250), v8(10, 10, 99, 3, 5, 1, 1, 100), 1'b0);
    x_idle;
    x_drain("R9 clamp beat emerged");
  endtask

  task automatic t_handshake;
    x_av = 1'b1; x_bv = 1'b0; x_ad = v8(1,1,1,1,1,1,1,1); x_bd = v8(1,1,1,1,1,1,1,1);
    repeat (3) begin
      @(negedge clk);
      chk(x_ar == 1'b0, "R7 a_ready low while b invalid", x_ar, 0);
      chk(x_br == 1'b1, "R7 b_ready high when a valid and empty", x_br, 1);
    end
    @(posedge clk); #1;
    x_av = 1'b0; x_bv = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk(x_br == 1'b0, "R7 b_ready low while a invalid", x_br, 0);
    end
    @(posedge clk); #1;
    x_idle;
    repeat (3) @(negedge clk);
    chk(x_ov == 1'b0, "R7 no beat from a single valid", x_ov, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_latency;
    cur_tag = "R9 latency beat";
    x_or = 1'b1; x_sc = 17'h10000;
    x_send(v8(2, 3, 4, 5, 6, 7, 8, 9), v8(2, 2, 2, 2, 2, 2, 2, 2), 1'b1);
    x_idle;
    @(negedge clk);
    chk(x_ov == 1'b0, "R9 not yet valid one edge after take", x_ov, 0);
    @(negedge clk);
    chk(x_ov == 1'b1, "R9 valid two edges after take", x_ov, 1);
    @(posedge clk); #1;
    x_drain("R9 latency beat emerged");
  endtask

  task automatic t_stall;
    logic [127:0] d0;
    x_or = 1'b0; x_sc = 17'h10000;
    cur_tag = "R8 first stalled beat";
    x_send(v8(11, 12, 13, 14, 15, 16, 17, 18), v8(-1, 2, -3, 4, -5, 6, -7, 8), 1'b1);
    x_idle;
    @(negedge clk);
    @(negedge clk);
    chk(x_ov == 1'b1, "R8 output valid under stall", x_ov, 1);
    d0 = x_od;
    @(posedge clk); #1;
    cur_tag = "R7 beat taken as stall releases";
    x_ad = v8(21, 22, 23, 24, 25, 26, 27, 28); x_bd = v8(2, 2, 2, 2, 2, 2, 2, 2);
    x_al = 1'b0; x_av = 1'b1; x_bv = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(x_ar == 1'b0, "R7 no take while output stalled and stage full", x_ar, 0);
      chk(x_ov == 1'b1 && x_od == d0, "R8 output held under stall", x_od, d0);
    end
    @(posedge clk); #1;
    x_or = 1'b1;
    do @(negedge clk); while (!x_ar);
    @(posedge clk); #1;
    x_idle;
    x_drain("R9 stall beats emerged in order");
  endtask

  task automatic t_burst;
    both_cnt = 0;
    x_sc = 17'h0A000;
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          cur_tag = "R9 R10 burst under toggling ready";
          x_send(v8(i, -i, 100+i, -100-i, 7*i, 300, -300, i*i),
                 v8(5, 5, i+1, i+2, -3, 200, 200, 9), (i == 5));
        end
        x_idle;
      end
      begin
        for (int i = 0; i < 16; i++) begin
          @(posedge clk); #1;
          x_or = ((i % 3) != 2);
        end
        x_or = 1'b1;
      end
    join
    x_drain("R9 burst beats all emerged");
    chk(both_cnt > 0, "R7 take and emit in the same cycle", both_cnt, 1);
  endtask

  task automatic t_wrap;
    y_or = 1'b1;
    cur_tag = "R3 R6 wrap unity";
    y_sc = 17'h10000;
    y_send({8'd3, 8'd255, 8'd200}, {8'd7, 8'd255, 8'd200}, 1'b0);
    y_idle;
    @(negedge clk);
    @(negedge clk);
    chk(y_ov == 1'b1 && y_od == 24'h150140, "R3 literal wrap result", y_od, 24'h150140);
    @(posedge clk); #1;
    cur_tag = "R3 R2 wrap half scale";
    y_sc = 17'h08000;
    y_send({8'd255, 8'd17, 8'd1}, {8'd255, 8'd3, 8'd1}, 1'b1);
    y_idle;
    repeat (6) @(negedge clk);
    chk(yq_d.size() == 0, "R9 wrap beats emerged", yq_d.size(), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    x_sc = '0; x_av = 0; x_bv = 0; x_al = 0; x_ad = '0; x_bd = '0; x_or = 1'b1;
    y_sc = '0; y_av = 0; y_bv = 0; y_al = 0; y_ad = '0; y_bd = '0; y_or = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_basic;
    t_round;
    t_sat;
    t_clamp;
    t_handshake;
    t_latency;
    t_stall;
    t_burst;
    t_wrap;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule